// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

`sc_core` is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. Its instruction set is deliberately narrow: wrapping register add and subtract, OR with a zero-extended 16-bit constant, word load, word store and branch-on-equal. The core holds the program counter, a 32-entry register file with two combinational read ports and one write port, the immediate extender, a three-function ALU and the writeback selection. All state updates on one common rising clock edge.

The core talks to two external memories through plain address/data ports. The instruction port shows the current PC and takes the instruction word back in the same cycle. The data port shows an address, write data and a write strobe, and takes read data back in the same cycle. Both memories are expected to answer reads combinationally and to write on the rising edge when the strobe is high.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets the PC (`imem_addr`) to 0. While `rst` is high, `dmem_we` is 0 and no register is written.
- R2: An instruction with opcode bits [31:26] = 000000, bits [10:6] = 0 and bits [5:0] = 100001 writes R[bits 25:21] + R[bits 20:16], modulo 2^32, into R[bits 15:11].
- R3: Opcode 000000 with bits [10:6] = 0 and bits [5:0] = 100011 writes R[bits 25:21] - R[bits 20:16], modulo 2^32, into R[bits 15:11].
- R4: Opcode 001101 writes R[bits 25:21] OR the zero-extended bits [15:0] into R[bits 20:16].
- R5: Opcode 100011 loads the data word at address R[bits 25:21] + sign-extended bits [15:0] into R[bits 20:16].
- R6: Opcode 101011 drives `dmem_we` = 1, `dmem_addr` = R[bits 25:21] + sign-extended bits [15:0] and `dmem_wdata` = R[bits 20:16]; no other instruction raises `dmem_we`.
- R7: Opcode 000100 sets the next PC to PC + 4 + (sign-extended bits [15:0] shifted left by 2) when R[bits 25:21] equals R[bits 20:16], and to PC + 4 otherwise; it writes no register.
- R8: Register 0 always reads as zero; any write aimed at it is discarded.
- R9: Any other opcode, and opcode 000000 with an unlisted bits [5:0] or a nonzero bits [10:6], writes neither a register nor memory.
- R10: Every instruction other than a taken branch advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Current PC, byte address of the instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written on the next rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The arithmetic program pairs a small and a large operand so that addition carries across bit 16 and subtraction produces negative results, separating true wrap-around from sign or carry mistakes, and feeds a constant with bit 15 set through the OR path to tell zero extension from sign extension. The load/store program uses negative offsets from a base register and adds a loaded all-ones word, which separates signed from unsigned offset extension and checks wrap at 2^32. Branch programs take a forward branch, fall through an unequal compare and take a backward branch, so the offset scaling, its sign and the equality test are each exposed by a different PC value. Writes aimed at register 0, unknown opcodes, unknown function codes and a nonzero shift field are then read back through later stores.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_ORI   = 6'b001101;
   localparam logic [5:0] OPC_LW    = 6'b100011;
   localparam logic [5:0] OPC_SW    = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;

   localparam logic [5:0] FN_ADDU   = 6'b100001;
   localparam logic [5:0] FN_SUBU   = 6'b100011;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_sel_e;

   typedef struct packed {
      logic     ext_sign;     // 1: sign-extend imm16, 0: zero-extend
      logic     b_from_imm;   // ALU B operand from the extender
      alu_sel_e alu_sel;
      logic     mem_write;
      logic     wb_from_mem;  // writeback from data memory
      logic     dest_is_rd;   // destination from bits 15:11
      logic     reg_write;
      logic     is_branch;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_core_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [4:0] shamt,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl          = '0;
      ctrl.ext_sign = 1'b1;
      ctrl.alu_sel  = ALU_ADD;
      case (opcode)
         OPC_RTYPE: begin
            if (shamt == 5'd0 && funct == FN_ADDU) begin
               ctrl.reg_write  = 1'b1;
               ctrl.dest_is_rd = 1'b1;
               ctrl.alu_sel    = ALU_ADD;
            end else if (shamt == 5'd0 && funct == FN_SUBU) begin
               ctrl.reg_write  = 1'b1;
               ctrl.dest_is_rd = 1'b1;
               ctrl.alu_sel    = ALU_SUB;
            end
         end
         OPC_ORI: begin
            ctrl.ext_sign   = 1'b0;
            ctrl.b_from_imm = 1'b1;
            ctrl.alu_sel    = ALU_OR;
            ctrl.reg_write  = 1'b1;
         end
         OPC_LW: begin
            ctrl.b_from_imm  = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.reg_write   = 1'b1;
         end
         OPC_SW: begin
            ctrl.b_from_imm = 1'b1;
            ctrl.mem_write  = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.alu_sel   = ALU_SUB;
            ctrl.is_branch = 1'b1;
         end
         default: ctrl = ctrl;
      endcase
   end

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
   parameter int XLEN     = 32,
   parameter int REG_AW   = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [XLEN-1:0]   wdata,
   input  logic [REG_AW-1:0] raddr_a,
   input  logic [REG_AW-1:0] raddr_b,
   output logic [XLEN-1:0]   rdata_a,
   output logic [XLEN-1:0]   rdata_b
);

   localparam int NREGS = 1 << REG_AW;

   logic [XLEN-1:0] bank [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (ZERO_REG && i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_ff
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (we && waddr == REG_AW'(i)) q <= wdata;
         end
         assign bank[i] = q;
      end
   end

   assign rdata_a = bank[raddr_a];
   assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_sel_e        sel,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   always_comb begin
      case (sel)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_pcgen.sv
module sc_pcgen #(
   parameter int          XLEN     = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic [XLEN-1:0] offset,
   output logic [XLEN-1:0] pc
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] tgt_pc;

   assign seq_pc = pc + STEP;
   assign tgt_pc = seq_pc + {offset[XLEN-3:0], 2'b00};

   always_ff @(posedge clk) begin
      if (rst)       pc <= XLEN'(RESET_PC);
      else if (take) pc <= tgt_pc;
      else           pc <= seq_pc;
   end

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_core_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          REG_AW   = 5,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);

   localparam int IMM_W = 16;
   localparam int EXT_W = XLEN - IMM_W;

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32");
   end
   if (REG_AW != 5) begin : g_bad_aw
      $error("sc_core: register fields are 5 bits wide");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("sc_core: RESET_PC must be word aligned");
   end

   logic [5:0]        f_op;
   logic [REG_AW-1:0] f_rs, f_rt, f_rd;
   logic [4:0]        f_sh;
   logic [5:0]        f_fn;
   logic [IMM_W-1:0]  f_imm;

   assign f_op  = imem_rdata[31:26];
   assign f_rs  = imem_rdata[25:21];
   assign f_rt  = imem_rdata[20:16];
   assign f_rd  = imem_rdata[15:11];
   assign f_sh  = imem_rdata[10:6];
   assign f_fn  = imem_rdata[5:0];
   assign f_imm = imem_rdata[15:0];

   ctrl_t             ctrl;
   logic [XLEN-1:0]   rs_val, rt_val;
   logic [XLEN-1:0]   imm_sext, imm_ext;
   logic [XLEN-1:0]   alu_b, alu_y;
   logic              alu_zero;
   logic              rf_we;
   logic [REG_AW-1:0] rf_waddr;
   logic [XLEN-1:0]   rf_wdata;
   logic              take_br;
   logic [XLEN-1:0]   pc;

   sc_decode u_dec (
      .opcode (f_op),
      .shamt  (f_sh),
      .funct  (f_fn),
      .ctrl   (ctrl)
   );

   assign imm_sext = {{EXT_W{f_imm[IMM_W-1]}}, f_imm};
   assign imm_ext  = ctrl.ext_sign ? imm_sext : {{EXT_W{1'b0}}, f_imm};

   assign rf_we    = ctrl.reg_write & ~rst;
   assign rf_waddr = ctrl.dest_is_rd ? f_rd : f_rt;
   assign rf_wdata = ctrl.wb_from_mem ? dmem_rdata : alu_y;

   sc_regbank #(
      .XLEN     (XLEN),
      .REG_AW   (REG_AW),
      .ZERO_REG (1'b1)
   ) u_rf (
      .clk     (clk),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (f_rs),
      .raddr_b (f_rt),
      .rdata_a (rs_val),
      .rdata_b (rt_val)
   );

   assign alu_b = ctrl.b_from_imm ? imm_ext : rt_val;

   sc_alu #(.XLEN(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .sel  (ctrl.alu_sel),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign take_br = ctrl.is_branch & alu_zero;

   sc_pcgen #(
      .XLEN     (XLEN),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk    (clk),
      .rst    (rst),
      .take   (take_br),
      .offset (imm_sext),
      .pc     (pc)
   );

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_we    = ctrl.mem_write & ~rst;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_core_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] imem_addr,
   input logic [31:0]     imem_rdata,
   input logic            dmem_we,
   input logic [XLEN-1:0] rs_val,
   input logic [XLEN-1:0] rt_val,
   input logic            rf_we
);

   logic [5:0]      op;
   logic [XLEN-1:0] br_off;
   logic            known_op;

   assign op       = imem_rdata[31:26];
   assign br_off   = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
   assign known_op = (op == OPC_RTYPE) || (op == OPC_ORI) || (op == OPC_LW) ||
                     (op == OPC_SW) || (op == OPC_BEQ);

   // R1
   pc_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> imem_addr == '0);

   // R6
   store_only_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> op == OPC_SW);

   // R7
   branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_BEQ && rs_val == rt_val) |=>
         imem_addr == $past(imem_addr) + XLEN'(4) + $past(br_off));

   // R7
   branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_BEQ && rs_val != rt_val) |=> imem_addr == $past(imem_addr) + XLEN'(4));

   // R10
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (op != OPC_BEQ) |=> imem_addr == $past(imem_addr) + XLEN'(4));

   // R8
   zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_rdata[25:21] == 5'd0) |-> rs_val == '0);

   // R9
   unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> (!rf_we && !dmem_we));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .imem_addr  (imem_addr),
   .imem_rdata (imem_rdata),
   .dmem_we    (dmem_we),
   .rs_val     (rs_val),
   .rt_val     (rt_val),
   .rf_we      (rf_we)
);

// File: tb/sc_core_test.sv
module sc_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sc_core uut (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
   end

   function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                         input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011,
                          BEQ = 6'b000100, ADDU = 6'b100001, SUBU = 6'b100011;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         imem[i] = 32'h0;
         dmem[i] = 32'hDEAD0000 | 32'(i);
      end
   endtask

   task automatic release_reset();
      rst = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      hold_reset();
      check("R1 pc in reset", imem_addr, 32'h0);
      check("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
      imem[0] = enc_i(SW, 0, 0, 16'h0);
      release_reset();
      step(3);
      rst = 1'b1;
      step(1);
      check("R1 pc after mid-run reset", imem_addr, 32'h0);
      check("R1 strobe held low", {31'b0, dmem_we}, 32'h0);
   endtask

   task automatic t_arith();
      hold_reset();
      imem[0] = enc_i(ORI, 0, 1, 16'h1234);
      imem[1] = enc_i(ORI, 0, 2, 16'hFFFF);
      imem[2] = enc_r(1, 2, 3, ADDU);
      imem[3] = enc_r(1, 2, 4, SUBU);
      imem[4] = enc_r(0, 1, 5, SUBU);
      imem[5] = enc_i(SW, 0, 3, 16'h0);
      imem[6] = enc_i(SW, 0, 4, 16'h4);
      imem[7] = enc_i(SW, 0, 5, 16'h8);
      imem[8] = enc_i(SW, 0, 2, 16'hC);
      release_reset();
      step(5);
      check("R6 store strobe", {31'b0, dmem_we}, 32'h1);
      check("R6 store address", dmem_addr, 32'h0);
      check("R6 store data", dmem_wdata, 32'h00011233);
      step(4);
      check("R2 add with carry", dmem[0], 32'h00011233);
      check("R3 sub negative", dmem[1], 32'hFFFF1235);
      check("R3 sub from zero", dmem[2], 32'hFFFFEDCC);
      check("R4 zero-extended or", dmem[3], 32'h0000FFFF);
   endtask

   task automatic t_ldst();
      hold_reset();
      dmem[16] = 32'hFFFFFFFF;
      dmem[17] = 32'h00000005;
      imem[0] = enc_i(ORI, 0, 1, 16'h0050);
      imem[1] = enc_i(LW, 1, 2, 16'hFFF0);
      imem[2] = enc_i(LW, 1, 3, 16'hFFF4);
      imem[3] = enc_r(2, 3, 4, ADDU);
      imem[4] = enc_i(SW, 1, 4, 16'h0004);
      imem[5] = enc_i(SW, 0, 2, 16'h0020);
      release_reset();
      step(6);
      check("R2 add wraps 2^32", dmem[21], 32'h00000004);
      check("R5 load negative offset", dmem[8], 32'hFFFFFFFF);
      check("R6 neighbour untouched", dmem[9], 32'hDEAD0009);
      check("R5 loaded words unchanged", dmem[17], 32'h00000005);
   endtask

   task automatic t_zero_reg();
      hold_reset();
      imem[0] = enc_i(ORI, 0, 0, 16'h7777);
      imem[1] = enc_i(LW, 0, 0, 16'h0040);
      imem[2] = enc_i(SW, 0, 0, 16'h0000);
      imem[3] = enc_r(0, 0, 1, ADDU);
      imem[4] = enc_i(SW, 0, 1, 16'h0004);
      release_reset();
      step(2);
      check("R8 r0 store data", dmem_wdata, 32'h0);
      step(3);
      check("R8 r0 after ori/lw", dmem[0], 32'h0);
      check("R8 r0+r0", dmem[1], 32'h0);
   endtask

   task automatic t_branch();
      hold_reset();
      imem[0] = enc_i(ORI, 0, 1, 16'd5);
      imem[1] = enc_i(ORI, 0, 2, 16'd5);
      imem[2] = enc_i(BEQ, 1, 2, 16'd2);
      imem[3] = enc_i(ORI, 0, 3, 16'h0BAD);
      imem[4] = enc_i(SW, 0, 3, 16'h0044);
      imem[5] = enc_i(ORI, 0, 4, 16'd1);
      imem[6] = enc_i(BEQ, 1, 4, 16'd5);
      imem[7] = enc_i(SW, 0, 4, 16'h0040);
      imem[8] = enc_i(BEQ, 0, 0, 16'hFFFE);
      release_reset();
      step(2);
      check("R10 sequential pc", imem_addr, 32'h8);
      step(1);
      check("R7 forward taken", imem_addr, 32'd20);
      step(2);
      check("R7 unequal falls through", imem_addr, 32'd28);
      step(2);
      check("R7 backward taken", imem_addr, 32'd28);
      check("R7 skipped store absent", dmem[17], 32'hDEAD0011);
      check("R7 store after fall-through", dmem[16], 32'h1);
   endtask

   task automatic t_unknown();
      hold_reset();
      imem[0] = enc_i(ORI, 0, 1, 16'd9);
      imem[1] = {6'b111111, 5'd0, 5'd1, 16'h0000};
      imem[2] = enc_r(0, 0, 1, 6'b100000);
      imem[3] = {6'b000000, 5'd0, 5'd0, 5'd1, 5'd3, ADDU};
      imem[4] = enc_i(SW, 0, 1, 16'h0000);
      release_reset();
      step(1);
      check("R9 no strobe on bad opcode", {31'b0, dmem_we}, 32'h0);
      step(3);
      check("R10 pc past unknowns", imem_addr, 32'd16);
      step(1);
      check("R9 r1 kept", dmem[0], 32'd9);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_ldst();
      t_zero_reg();
      t_branch();
      t_unknown();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule